// File: doc/BRIEF.md
# Converter Clock and Word-Rate Controller

This block holds the clock-control byte of a sigma-delta converter and turns it into the timing that the rest of the converter needs. It produces a gated copy of the master clock for other devices on the board. It produces an internal clock enable, which is either every cycle or every second cycle. It also produces a one-cycle strobe each time a new output word would leave the decimation filter.

The word rate comes from a 3-bit code: a clock-range bit joined with two filter-select bits. Each code maps to a fixed number of internal clock ticks per word. The block also counts the words that follow a filter restart and raises a settled flag once the result can be trusted. That takes four word periods after an unsynchronised change. It takes three word periods when the filter was held in reset across the change by the filter-hold input. Any write that alters the rate code raises a sticky flag that recommends a recalibration. The next filter hold clears that flag.

Top module: `clkrate_ctrl`

## Requirements
- R1: After reset the register reads 0x05, the recalibration flag is 0, the settled flag is 0 and no word strobe is active.
- R2: Bits 7..5 of the register ignore writes and always read as zero. Bits 4..0 read back as written: bit 4 is clock-out off, bit 3 is divide-by-two, bit 2 is clock range, and bits 1..0 are the filter select.
- R3: While bit 4 is 1 the clock output stays low. While bit 4 is 0 the clock output follows the master clock, with a change taking effect from the next falling edge.
- R4: While bit 3 is 0 the internal tick is high on every cycle. While bit 3 is 1 the tick is high on every second cycle.
- R5: The word strobe is a single-cycle pulse. Its period is N internal ticks, where N = F / rate / SCALE with a minimum of 2. F is HZ_LO when bit 2 is 0 and HZ_HI when bit 2 is 1. The rate for code {bit2,bit1,bit0} is 20, 25, 100, 200, 50, 60, 250 or 500 Hz for codes 0 to 7.
- R6: While the filter-hold input is high, no strobe is issued, the period counter stays at zero and the settled flag is 0.
- R7: After the filter-hold input falls, the settled flag rises together with the third word strobe.
- R8: After reset, or after a write that changes bits 2..0, the settled flag is 0 and rises together with the fourth word strobe.
- R9: A write that changes bits 2..0 sets the recalibration flag from the next cycle. A write that changes only bits 4..3 leaves the flag unchanged. A high filter-hold input clears the flag, but a code-changing write in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| fsync_i | input | 1 | Filter hold: restarts the word timing while high |
| rd_data_o | output | 8 | Register read-back |
| mclk_out_o | output | 1 | Gated master clock output |
| int_tick_o | output | 1 | Internal clock enable after the optional divide-by-two |
| word_stb_o | output | 1 | One-cycle pulse per output word |
| settled_o | output | 1 | Filter result is settled |
| cal_req_o | output | 1 | Recalibration recommended |

## Verification
The bench builds the block with SCALE = 1000 and keeps HZ_LO = 1,000,000 and HZ_HI = 2,457,600. This shrinks word periods to between 4 and 50 ticks. Several complete settling sequences therefore fit in a short run: after reset, after a code change, after a filter hold, and with the divider on. The fastest code gives 4 ticks per word and brings the minimum-period pulse spacing within reach. With the divider on, the 8-cycle spacing shows that the tick and the period counter compose correctly.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

  // Register fields below the three reserved bits, MSB first.
  typedef struct packed {
    logic       clk_off;   // bit 4: gate the clock output low
    logic       div2;      // bit 3: divide input clock by two
    logic       range_hi;  // bit 2: high clock range
    logic [1:0] fsel;      // bits 1..0: filter select
  } clk_cfg_t;

  localparam logic [4:0] CFG_RESET = 5'b00101;

  // Word rate in Hz for a rate code {range_hi, fsel}.
  function automatic int unsigned rate_hz(input int unsigned code);
    case (code)
      0:       rate_hz = 20;
      1:       rate_hz = 25;
      2:       rate_hz = 100;
      3:       rate_hz = 200;
      4:       rate_hz = 50;
      5:       rate_hz = 60;
      6:       rate_hz = 250;
      default: rate_hz = 500;
    endcase
  endfunction

  // Internal ticks per output word, clamped to at least two.
  function automatic int unsigned word_ticks(input int unsigned code,
                                             input int unsigned hz_lo,
                                             input int unsigned hz_hi,
                                             input int unsigned scale);
    int unsigned base;
    base = (code >= 4) ? hz_hi : hz_lo;
    word_ticks = base / rate_hz(code) / scale;
    if (word_ticks < 2) word_ticks = 2;
  endfunction

  function automatic int unsigned max_ticks(input int unsigned hz_lo,
                                            input int unsigned hz_hi,
                                            input int unsigned scale);
    max_ticks = 2;
    for (int unsigned c = 0; c < 8; c++) begin
      if (word_ticks(c, hz_lo, hz_hi, scale) > max_ticks)
        max_ticks = word_ticks(c, hz_lo, hz_hi, scale);
    end
  endfunction

endpackage

// File: rtl/clkrate_cfg_reg.sv
module clkrate_cfg_reg
  import clkrate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       fsync_i,
  output clk_cfg_t   cfg_o,
  output logic       code_chg_o,
  output logic       cal_req_o
);

  clk_cfg_t cfg_q, cfg_d;
  logic     cal_q, cal_d;
  logic     code_chg;

  // Only the low five bits are stored; the reserved bits are dropped here.
  assign code_chg = wr_en_i &&
                    (wr_data_i[2:0] != {cfg_q.range_hi, cfg_q.fsel});

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) cfg_d = clk_cfg_t'(wr_data_i[4:0]);
  end

  always_comb begin
    cal_d = cal_q;
    if (code_chg)     cal_d = 1'b1;
    else if (fsync_i) cal_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= clk_cfg_t'(CFG_RESET);
      cal_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      cal_q <= cal_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign code_chg_o = code_chg;
  assign cal_req_o  = cal_q;

endmodule

// File: rtl/clkrate_clk_gen.sv
module clkrate_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div2_i,
  input  logic clk_off_i,
  output logic tick_o,
  output logic gate_en_o,
  output logic mclk_out_o
);

  logic div_q, div_d;
  logic gate_q;

  // Phase toggle for divide-by-two; parked at zero when not dividing.
  always_comb begin
    div_d = 1'b0;
    if (div2_i) div_d = ~div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= div_d;
  end

  assign tick_o = ~div2_i | div_q;

  // Enable captured on the falling edge so the AND below cannot glitch.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= ~clk_off_i;
  end

  assign gate_en_o  = gate_q;
  assign mclk_out_o = clk_i & gate_q;

endmodule

// File: rtl/clkrate_word_timer.sv
module clkrate_word_timer
  import clkrate_pkg::*;
#(
  parameter int unsigned HZ_LO = 1_000_000,
  parameter int unsigned HZ_HI = 2_457_600,
  parameter int unsigned SCALE = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       stb_o,
  output logic       settled_o
);

  localparam int unsigned MAXT = max_ticks(HZ_LO, HZ_HI, SCALE);
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam int unsigned SW   = 3;
  localparam logic [SW-1:0] SAT = SW'(4);

  logic [CW-1:0] last_tbl [8];

  for (genvar g = 0; g < 8; g++) begin : g_tbl
    localparam int unsigned T = word_ticks(g, HZ_LO, HZ_HI, SCALE);
    assign last_tbl[g] = CW'(T - 1);
  end

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] nw_q, nw_d;
  logic          stb_q, stb_d;
  logic          sync_q, sync_d;

  always_comb begin
    cnt_d  = cnt_q;
    nw_d   = nw_q;
    stb_d  = 1'b0;
    sync_d = sync_q;
    if (hold_i) begin
      cnt_d  = '0;
      nw_d   = '0;
      sync_d = 1'b1;
    end else if (restart_i) begin
      cnt_d  = '0;
      nw_d   = '0;
      sync_d = 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= last_tbl[code_i]) begin
        cnt_d = '0;
        stb_d = 1'b1;
        if (nw_q != SAT) nw_d = nw_q + SW'(1);
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      nw_q   <= '0;
      stb_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      nw_q   <= nw_d;
      stb_q  <= stb_d;
      sync_q <= sync_d;
    end
  end

  assign stb_o     = stb_q;
  assign settled_o = sync_q ? (nw_q >= SW'(3)) : (nw_q >= SW'(4));

endmodule

// File: rtl/clkrate_ctrl.sv
module clkrate_ctrl
  import clkrate_pkg::*;
#(
  parameter int unsigned HZ_LO = 1_000_000,
  parameter int unsigned HZ_HI = 2_457_600,
  parameter int unsigned SCALE = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       fsync_i,
  output logic [7:0] rd_data_o,
  output logic       mclk_out_o,
  output logic       int_tick_o,
  output logic       word_stb_o,
  output logic       settled_o,
  output logic       cal_req_o
);

  clk_cfg_t cfg;
  logic     code_chg;
  logic     tick;
  logic     gate_en;

  clkrate_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .fsync_i    (fsync_i),
    .cfg_o      (cfg),
    .code_chg_o (code_chg),
    .cal_req_o  (cal_req_o)
  );

  clkrate_clk_gen u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div2_i     (cfg.div2),
    .clk_off_i  (cfg.clk_off),
    .tick_o     (tick),
    .gate_en_o  (gate_en),
    .mclk_out_o (mclk_out_o)
  );

  clkrate_word_timer #(
    .HZ_LO (HZ_LO),
    .HZ_HI (HZ_HI),
    .SCALE (SCALE)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .hold_i    (fsync_i),
    .restart_i (code_chg),
    .code_i    ({cfg.range_hi, cfg.fsel}),
    .stb_o     (word_stb_o),
    .settled_o (settled_o)
  );

  assign rd_data_o  = {3'b000, cfg};
  assign int_tick_o = tick;

endmodule

// File: rtl/clkrate_ctrl_chk.sv
module clkrate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       fsync_i,
  input logic [7:0] rd_data_o,
  input logic       int_tick_o,
  input logic       word_stb_o,
  input logic       settled_o,
  input logic       cal_req_o,
  input logic       gate_en
);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:5] == 3'b000);

  p_gate_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[4] |-> !gate_en);

  p_tick_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[3] |-> int_tick_o);

  p_tick_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[3] && int_tick_o) |=> (!int_tick_o || !rd_data_o[3]));

  p_stb_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o);

  p_hold_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fsync_i) |-> (!word_stb_o && !settled_o));

  p_cal_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[2:0] != rd_data_o[2:0])) |=> cal_req_o);

endmodule

bind clkrate_ctrl clkrate_ctrl_chk u_chk (.*);

// File: tb/tb_clkrate_ctrl.sv
module tb_clkrate_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ_LO = 1_000_000;
  localparam int unsigned HZ_HI = 2_457_600;
  localparam int unsigned SCALE = 1000;
  localparam int WATCHDOG = 150_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       fsync_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       mclk_out_o, int_tick_o, word_stb_o, settled_o, cal_req_o;

  clkrate_ctrl #(.HZ_LO(HZ_LO), .HZ_HI(HZ_HI), .SCALE(SCALE)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {int gap; bit settled; string req;} exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected ticks per word from the rate rule of R5.
  function automatic int ticks_for(input int code);
    int rates [8] = '{20, 25, 100, 200, 50, 60, 250, 500};
    int t;
    t = ((code >= 4) ? HZ_HI : HZ_LO) / rates[code] / SCALE;
    return (t < 2) ? 2 : t;
  endfunction

  // Monitor: compares spacing and settled flag at each strobe.
  int cyc = 0;
  int last_stb = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (word_stb_o) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(cyc - last_stb == e.gap, {e.req, " gap"}, cyc - last_stb, e.gap);
        check(settled_o == e.settled, {e.req, " settled"}, settled_o, e.settled);
      end
      last_stb = cyc;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // Driver: after the first strobe, push expectations for strobes 2..n.
  task automatic run_words(input int code, input bit div, input int n,
                           input int need, input string req);
    while (!word_stb_o) @(negedge clk_i);
    @(negedge clk_i);
    for (int k = 2; k <= n; k++) begin
      exp_t e;
      e.gap = ticks_for(code) * (div ? 2 : 1);
      e.settled = (k >= need);
      e.req = req;
      q.push_back(e);
    end
    while (q.size() != 0) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int ones;
    int stbs;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(rd_data_o == 8'h05, "R1 reg", rd_data_o, 8'h05);
    check(cal_req_o == 0, "R1 cal", cal_req_o, 0);
    check(settled_o == 0 && word_stb_o == 0, "R1 settled/stb", settled_o, 0);
    rst_ni = 1'b1;

    // R9: only the clock-off bit changes, so the flag stays low; R3 gate
    wr(8'h15);
    check(rd_data_o == 8'h15, "R2 readback", rd_data_o, 8'h15);
    check(cal_req_o == 0, "R9 no set on bit4", cal_req_o, 0);
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(mclk_out_o == 0, "R3 gated low", mclk_out_o, 0);
    wr(8'hF5);
    check(rd_data_o == 8'h15, "R2 reserved masked", rd_data_o, 8'h15);
    wr(8'h05);
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(mclk_out_o == 1, "R3 clock high phase", mclk_out_o, 1);
    @(negedge clk_i); #(CLK_PERIOD/4);
    check(mclk_out_o == 0, "R3 clock low phase", mclk_out_o, 0);

    // R5/R8: reset code 5, settled with the fourth strobe after reset
    run_words(5, 0, 6, 4, "R5 R8 reset code");

    // R9 set on code change; R5/R8 at fastest code 7
    wr(8'h07);
    check(cal_req_o == 1, "R9 set on code change", cal_req_o, 1);
    check(settled_o == 0, "R8 cleared on change", settled_o, 0);
    run_words(7, 0, 6, 4, "R5 R8 code 7");

    // R6 hold, R9 clear
    @(negedge clk_i);
    fsync_i = 1'b1;
    @(negedge clk_i);
    check(cal_req_o == 0, "R9 cleared by hold", cal_req_o, 0);
    stbs = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (word_stb_o) stbs++;
    end
    check(stbs == 0, "R6 no strobes in hold", stbs, 0);
    check(settled_o == 0, "R6 settled low in hold", settled_o, 0);
    fsync_i = 1'b0;
    // R7: settled at the third strobe after release
    run_words(7, 0, 5, 3, "R7 after hold");

    // R4 divider, R5 doubled spacing, settling unaffected
    wr(8'h0F);
    check(cal_req_o == 0, "R9 no set on bit3", cal_req_o, 0);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (int_tick_o) ones++;
    end
    check(ones == 10, "R4 half-rate tick", ones, 10);
    run_words(7, 1, 4, 0, "R5 R4 divided");
    wr(8'h07);
    ones = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (int_tick_o) ones++;
    end
    check(ones == 10, "R4 full-rate tick", ones, 10);

    // Low range code 2
    wr(8'h02);
    check(cal_req_o == 1, "R9 set again", cal_req_o, 1);
    run_words(2, 0, 6, 4, "R5 R8 code 2");

    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule